// File: doc/BRIEF.md
# Three-Port Register File

This block holds the general-purpose registers of a 32-bit load/store processor: 32 words of 32 bits each. Two read ports, A and B, each take a register index and return that register's contents through purely combinational logic. No clock latency is involved, so a decode stage can fetch both source operands in the same cycle it presents their indices. One write port stores a word on the rising clock edge when its enable is high.

Index 0 is a constant zero. It reads as zero at all times, and any write aimed at it is dropped. There is no bypass from the write port to the read ports. Forwarding a value in the cycle it is written is left to the surrounding pipeline. A synchronous active-high reset clears every register.

Top module: `rf3p_top`

## Requirements
- R1: Each of the 32 registers, indexed 0 to 31, stores an independent 32-bit word. Writing one index leaves every other index unchanged.
- R2: When `wr_en` is 1 at a rising edge of `clk`, the register at index `wr_addr` (other than 0) takes `wr_data`. The new value is seen on a read port from the following cycle.
- R3: When `wr_en` is 0 at a rising edge, no register changes, whatever `wr_addr` and `wr_data` hold.
- R4: `rd_data_a` follows `rd_addr_a` combinationally, with no clock edge needed. `rd_data_b` follows `rd_addr_b` in the same way.
- R5: When both read ports select the same index, they return the same value.
- R6: Index 0 always reads as 0, including after a write with `wr_en` = 1 aimed at index 0.
- R7: When a read port selects the index being written, it shows the old value until the write edge and the new value after it.
- R8: While `rst` is 1 at a rising edge, every register is cleared to 0. This takes priority over a write in that same cycle.
- R9: Writes to the same index on consecutive edges leave the value of the last write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Index of the register to write |
| wr_data | input | 32 | Word to write |
| rd_addr_a | input | 5 | Index read by port A |
| rd_data_a | output | 32 | Contents of the register at `rd_addr_a` |
| rd_addr_b | input | 5 | Index read by port B |
| rd_data_b | output | 32 | Contents of the register at `rd_addr_b` |

## Verification
Every index is written with a distinct, index-derived word. The file is then swept with port A running upward and port B running downward. This pattern exposes address aliasing and crossed ports, and it shows whether the dropped write to index 0 took effect. A sweep with both ports on the same index checks that the ports agree. A walking-one pattern through one register separates stuck or swapped data bits. Finally, a directed sequence separates a missing write from a bypass or a stale read:
- a disabled write,
- a read of the index being written, sampled before and after the edge,
- three writes in a row to one index,
- a reset asserted together with a write.

// File: rtl/rf3p_pkg.sv
package rf3p_pkg;
    parameter int RF_WORDS = 32;
    parameter int RF_WIDTH = 32;
    localparam int RF_AW = $clog2(RF_WORDS);

    typedef logic [RF_WIDTH-1:0] rf_word_t;
    typedef logic [RF_AW-1:0]    rf_idx_t;

    typedef struct packed {
        rf_word_t [RF_WORDS-1:0] word;
    } rf_state_t;
endpackage

// File: rtl/rf3p_wdec.sv
module rf3p_wdec #(
    parameter int N  = 32,
    parameter int AW = 5
) (
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  sel
);
    for (genvar i = 0; i < N; i++) begin : g_sel
        if (i == 0) begin : g_zero
            assign sel[i] = 1'b0;
        end else begin : g_live
            assign sel[i] = en && (addr == AW'(i));
        end
    end
endmodule

// File: rtl/rf3p_rdmux.sv
module rf3p_rdmux #(
    parameter int N  = 32,
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic [N-1:0][W-1:0] words,
    input  logic [AW-1:0]       addr,
    output logic [W-1:0]        data
);
    always_comb begin
        data = words[addr];
    end
endmodule

// File: rtl/rf3p_top.sv
module rf3p_top
    import rf3p_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  rf_idx_t  wr_addr,
    input  rf_word_t wr_data,
    input  rf_idx_t  rd_addr_a,
    output rf_word_t rd_data_a,
    input  rf_idx_t  rd_addr_b,
    output rf_word_t rd_data_b
);
    localparam int NPORTS = 2;

    rf_state_t           st_d, st_q;
    logic [RF_WORDS-1:0] wsel;
    rf_idx_t             raddr [NPORTS];
    rf_word_t            rdata [NPORTS];

    rf3p_wdec #(.N(RF_WORDS), .AW(RF_AW)) i_wdec (
        .en   (wr_en),
        .addr (wr_addr),
        .sel  (wsel)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < RF_WORDS; i++) begin
            if (wsel[i]) begin
                st_d.word[i] = wr_data;
            end
        end
        if (rst) begin
            st_d = '0;
        end
        st_d.word[0] = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign raddr[0] = rd_addr_a;
    assign raddr[1] = rd_addr_b;

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        rf3p_rdmux #(.N(RF_WORDS), .W(RF_WIDTH), .AW(RF_AW)) i_mux (
            .words (st_q.word),
            .addr  (raddr[p]),
            .data  (rdata[p])
        );
    end

    assign rd_data_a = rdata[0];
    assign rd_data_b = rdata[1];
endmodule

// File: rtl/rf3p_chk.sv
module rf3p_chk
    import rf3p_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     wr_en,
    input rf_idx_t  wr_addr,
    input rf_word_t wr_data,
    input rf_idx_t  rd_addr_a,
    input rf_word_t rd_data_a,
    input rf_idx_t  rd_addr_b,
    input rf_word_t rd_data_b
);
    a_r6_zero_a: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    a_r6_zero_b: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    a_r5_ports_agree: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

    a_r2_write_seen: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && !rst && (wr_addr != '0)) && (rd_addr_a == $past(wr_addr)))
        |-> (rd_data_a == $past(wr_data)));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && !wr_en) && $stable(rd_addr_b)) |-> $stable(rd_data_b));

    a_r8_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data_a == '0 && rd_data_b == '0));
endmodule

bind rf3p_top rf3p_chk i_chk (.*);

// File: tb/test_rf3p_top.sv
`timescale 1ns/1ps
module test_rf3p_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr_a = '0;
    logic [31:0] rd_data_a;
    logic [4:0]  rd_addr_b = '0;
    logic [31:0] rd_data_b;

    logic [31:0] model [32];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rf3p_top i_rf3p_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic en);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = en;
        @(posedge clk);
        if (en && a != 0) model[a] = d;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [4:0] b);
        @(negedge clk);
        rd_addr_a = a; rd_addr_b = b;
        #0.5;
        chk(req, rd_data_a, model[a]);
        chk(req, rd_data_b, model[b]);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R8: reset state
        for (int i = 0; i < 32; i++) rd("R8 reset", 5'(i), 5'(31 - i));

        // R1, R6: distinct word per index, index 0 write dropped
        for (int i = 0; i < 32; i++) wr(5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101), 1'b1);
        idle();
        for (int i = 0; i < 32; i++) rd("R1 sweep", 5'(i), 5'(31 - i));
        rd("R6 zero", 5'd0, 5'd0);

        // R3: disabled write has no effect
        wr(5'd5, 32'hDEADBEEF, 1'b0);
        idle();
        rd("R3 no write", 5'd5, 5'd6);

        // R5: both ports on same index
        for (int i = 0; i < 32; i++) rd("R5 same", 5'(i), 5'(i));

        // R4: address change seen without a clock edge
        @(negedge clk);
        rd_addr_a = 5'd12; #0.3;
        chk("R4 comb", rd_data_a, model[12]);
        rd_addr_a = 5'd13; #0.3;
        chk("R4 comb", rd_data_a, model[13]);

        // R7: read during write, old before edge, new after
        @(negedge clk);
        wr_addr = 5'd7; wr_data = 32'h0BADF00D; wr_en = 1'b1; rd_addr_a = 5'd7; rd_addr_b = 5'd7;
        #0.5;
        chk("R7 before", rd_data_a, model[7]);
        @(posedge clk); model[7] = 32'h0BADF00D; #1;
        chk("R7 after", rd_data_a, 32'h0BADF00D);
        chk("R7 after", rd_data_b, 32'h0BADF00D);
        idle();

        // R9: back-to-back writes to one index
        wr(5'd9, 32'h11111111, 1'b1);
        wr(5'd9, 32'h22222222, 1'b1);
        wr(5'd9, 32'h33333333, 1'b1);
        idle();
        rd("R9 last wins", 5'd9, 5'd8);
        chk("R9 value", rd_data_a, 32'h33333333);

        // R2: walking one through register 31
        for (int b = 0; b < 32; b++) begin
            wr(5'd31, 32'h1 << b, 1'b1);
            idle();
            rd("R2 walk", 5'd31, 5'd30);
        end

        // R8: reset beats a simultaneous write
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd3; wr_data = 32'hCAFE0003;
        @(posedge clk);
        @(negedge clk); rst = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        for (int i = 0; i < 32; i++) rd("R8 reset wins", 5'(i), 5'(i ^ 1));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule